// File: doc/BRIEF.md
# Synchronous Serial Port Core

This block is a word-oriented serial transmit and receive engine for a point-to-point synchronous link with a single master-driven frame format. Software-side logic loads words into a small transmit queue. The engine takes each word in turn and shifts it out most-significant bit first. While it does so, it captures the same number of bits from the receive pin into a receive queue. The frame length can be set anywhere from 4 to 16 bits with a 4-bit size code. A loopback switch ties the transmit shifter straight to the receive shifter, which lets the data path test itself without external wiring.

Each queue raises a service-request flag from its fill level. The transmit flag means "nearly empty, refill me". The receive flag means "holding enough words, drain me". Each flag has an interrupt enable. The enable gates only the interrupt output and never touches the flag itself. The serial clock comes from a plain divider of the system clock, and it idles low between frames.

Top module: `ssp_core`

## Requirements
- R1: After reset the 16-bit control word reads 0. Its layout is bits [3:0] size code, bit 4 loopback, bit 5 receive interrupt enable, bit 6 transmit interrupt enable, and bits [15:7] always read 0.
- R2: With size code c in 3..15, a frame carries c+1 bits. Each bit gets exactly one rising edge of `ser_clk`. The bits are driven on `ser_out` most-significant first, starting at bit c of the queued word. Bits of the word above the frame length are ignored.
- R3: The size codes 0, 1 and 2 are handled as 4-bit frames.
- R4: Each bit is sampled at the rising edge of `ser_clk`, and the last bit sampled lands in bit 0 of the received word. The received word is right-aligned and its bits above the frame length read 0.
- R5: With loopback 0 the receive shifter takes its bits from the `ser_in` pin.
- R6: With loopback 1 the receive shifter takes the transmit shifter output, `ser_in` has no effect, and the received word equals the transmitted word masked to the frame length.
- R7: `tx_req` is 1 exactly when the transmit queue holds TX_THR words or fewer (default 1). `rx_req` is 1 exactly when the receive queue holds RX_THR words or more (default 2).
- R8: `tx_irq` is `tx_req` AND the transmit enable, and `rx_irq` is `rx_req` AND the receive enable, in the same cycle. Clearing an enable leaves its flag unchanged.
- R9: A push into a full transmit queue is ignored and `tx_full` reads 1. A frame that completes while the receive queue is full is discarded, and the words already queued are kept.
- R10: `ser_frm` is high for exactly 2*DIV*(frame length) system clock cycles per frame. `ser_clk` is low whenever `ser_frm` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word readback |
| tx_push | input | 1 | Enqueue `tx_data` into the transmit queue |
| tx_data | input | 16 | Word to transmit, right-aligned |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Dequeue the head of the receive queue |
| rx_data | output | 16 | Head of the receive queue (show-ahead) |
| rx_empty | output | 1 | Receive queue empty |
| tx_req | output | 1 | Transmit service-request flag |
| rx_req | output | 1 | Receive service-request flag |
| tx_irq | output | 1 | Masked transmit interrupt request |
| rx_irq | output | 1 | Masked receive interrupt request |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_frm | output | 1 | Frame active, high for the whole frame |
| ser_out | output | 1 | Serial data out |
| ser_in | input | 1 | Serial data in |

## Verification
Loopback frames carry random words under every size code, including the reserved codes. These runs separate correct masking and MSB-first order from off-by-one frame lengths. During the same runs `ser_in` is driven with an unrelated pattern, which shows whether the pin leaks into the loop. Runs with the loopback off use a bench slave that answers with its own word. This exposes a receive path that listens to the wrong source, or to the right source on the wrong edge. Directed sequences then fill and drain both queues across their thresholds, toggle the interrupt enables, and overfill both queues, which separates flag, gating and drop behaviour.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int WORD_W = 16;
    localparam int LEN_W  = 5;

    typedef struct packed {
        logic       tx_ie;
        logic       rx_ie;
        logic       loop;
        logic [3:0] size_code;
    } ssp_cfg_t;

    localparam int CFG_W = $bits(ssp_cfg_t);

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOW  = 2'd1,
        ENG_HIGH = 2'd2
    } eng_state_e;

    // Frame length for a size code; codes below 3 fall back to 4 bits.
    function automatic logic [LEN_W-1:0] frame_len(input logic [3:0] code);
        if (code < 4'd3)
            return 5'd4;
        return {1'b0, code} + 5'd1;
    endfunction

    function automatic logic [WORD_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [WORD_W:0] t;
        t = ({{WORD_W{1'b0}}, 1'b1} << len) - 1'b1;
        return t[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/ssp_cfg_reg.sv
module ssp_cfg_reg
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output ssp_cfg_t          cfg,
    output logic [WORD_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (we)
            cfg <= ssp_cfg_t'(wdata[CFG_W-1:0]);
    end

    assign rdata = {{(WORD_W-CFG_W){1'b0}}, cfg};

endmodule

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
    import ssp_pkg::*;
#(
    parameter int DIV = 2,
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_avail,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_take,
    input  logic [3:0]        size_code,
    input  logic              loop,
    input  logic              ser_in,
    output logic              ser_clk,
    output logic              ser_frm,
    output logic              ser_out,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_word
);

    eng_state_e        state;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic [LEN_W-1:0]  bits_left;
    logic [LEN_W-1:0]  start_len;
    logic              tick;
    logic              rx_bit;

    // Divider: one tick every DIV cycles of an active phase.
    generate
        if (DIV == 1) begin : g_div_bypass
            assign tick = 1'b1;
        end else begin : g_div_count
            logic [DW-1:0] div_cnt;
            always_ff @(posedge clk) begin
                if (rst || state == ENG_IDLE || tick)
                    div_cnt <= '0;
                else
                    div_cnt <= div_cnt + 1'b1;
            end
            assign tick = (div_cnt == DW'(DIV - 1));
        end
    endgenerate

    assign start_len = frame_len(size_code);
    assign tx_take   = (state == ENG_IDLE) && tx_avail;
    assign ser_out   = tx_sh[WORD_W-1];
    assign rx_bit    = loop ? ser_out : ser_in;
    assign rx_word   = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            tx_sh     <= '0;
            rx_sh     <= '0;
            bits_left <= '0;
            ser_clk   <= 1'b0;
            ser_frm   <= 1'b0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                ENG_IDLE: begin
                    if (tx_avail) begin
                        tx_sh     <= (tx_word & len_mask(start_len)) << (5'd16 - start_len);
                        rx_sh     <= '0;
                        bits_left <= start_len;
                        ser_frm   <= 1'b1;
                        state     <= ENG_LOW;
                    end
                end
                ENG_LOW: begin
                    if (tick) begin
                        ser_clk <= 1'b1;
                        rx_sh   <= {rx_sh[WORD_W-2:0], rx_bit};
                        state   <= ENG_HIGH;
                    end
                end
                ENG_HIGH: begin
                    if (tick) begin
                        ser_clk <= 1'b0;
                        if (bits_left == 5'd1) begin
                            ser_frm  <= 1'b0;
                            rx_valid <= 1'b1;
                            tx_sh    <= '0;
                            state    <= ENG_IDLE;
                        end else begin
                            tx_sh     <= tx_sh << 1;
                            bits_left <= bits_left - 1'b1;
                            state     <= ENG_LOW;
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ssp_core.sv
module ssp_core
    import ssp_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int TX_THR = 1,
    parameter int RX_THR = 2,
    parameter int DIV    = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic        tx_push,
    input  logic [15:0] tx_data,
    output logic        tx_full,
    input  logic        rx_pop,
    output logic [15:0] rx_data,
    output logic        rx_empty,
    output logic        tx_req,
    output logic        rx_req,
    output logic        tx_irq,
    output logic        rx_irq,
    output logic        ser_clk,
    output logic        ser_frm,
    output logic        ser_out,
    input  logic        ser_in
);

    localparam int LW = $clog2(DEPTH + 1);

    ssp_cfg_t          cfg;
    logic              tx_empty, tx_take, rx_valid, rx_full_unused;
    logic [WORD_W-1:0] tx_head, rx_word;
    logic [LW-1:0]     tx_lvl, rx_lvl;

    ssp_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    ssp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .din   (tx_data),
        .pop   (tx_take),
        .dout  (tx_head),
        .full  (tx_full),
        .empty (tx_empty),
        .level (tx_lvl)
    );

    ssp_engine #(.DIV(DIV)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .tx_avail  (!tx_empty),
        .tx_word   (tx_head),
        .tx_take   (tx_take),
        .size_code (cfg.size_code),
        .loop      (cfg.loop),
        .ser_in    (ser_in),
        .ser_clk   (ser_clk),
        .ser_frm   (ser_frm),
        .ser_out   (ser_out),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word)
    );

    ssp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_valid),
        .din   (rx_word),
        .pop   (rx_pop),
        .dout  (rx_data),
        .full  (rx_full_unused),
        .empty (rx_empty),
        .level (rx_lvl)
    );

    assign tx_req = (tx_lvl <= LW'(TX_THR));
    assign rx_req = (rx_lvl >= LW'(RX_THR));
    assign tx_irq = tx_req & cfg.tx_ie;
    assign rx_irq = rx_req & cfg.rx_ie;

endmodule

// File: rtl/ssp_core_chk.sv
module ssp_core_chk #(
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [15:0]   cfg_rdata,
    input logic          ser_clk,
    input logic          ser_frm,
    input logic          ser_out,
    input logic          tx_req,
    input logic          rx_req,
    input logic          tx_irq,
    input logic          rx_irq,
    input logic          rx_empty,
    input logic [LW-1:0] tx_lvl,
    input logic [LW-1:0] rx_lvl
);

    p_cfg_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_rdata == 16'h0000);

    p_out_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_out));

    p_rx_req_data_r7: assert property (@(posedge clk) disable iff (rst)
        rx_req |-> !rx_empty);

    p_tx_irq_flag_r8: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> tx_req);

    p_rx_irq_flag_r8: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rx_req);

    p_tx_irq_en_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_req && cfg_rdata[6]) |-> tx_irq);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

    p_clk_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !ser_frm |-> !ser_clk);

endmodule

bind ssp_core ssp_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .ser_clk   (ser_clk),
    .ser_frm   (ser_frm),
    .ser_out   (ser_out),
    .tx_req    (tx_req),
    .rx_req    (rx_req),
    .tx_irq    (tx_irq),
    .rx_irq    (rx_irq),
    .rx_empty  (rx_empty),
    .tx_lvl    (tx_lvl),
    .rx_lvl    (rx_lvl)
);

// File: tb/ssp_core_tb_top.sv
module ssp_core_tb_top;

    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        tx_push = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_full;
    logic        rx_pop = 1'b0;
    logic [15:0] rx_data;
    logic        rx_empty, tx_req, rx_req, tx_irq, rx_irq;
    logic        ser_clk, ser_frm, ser_out;
    logic        ser_in = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Bench-side link monitor and slave state
    int          exp_len = 4;
    logic [15:0] slave_word = '0;
    int          sidx = 0;
    logic        prev_frm = 1'b0, prev_clk = 1'b0;
    int          fcyc = 0, last_fcyc = 0;
    int          nbits = 0, last_nbits = 0;
    logic [15:0] cap = '0, last_cap = '0;
    int          fcount = 0;

    ssp_core #(.DEPTH(4), .TX_THR(1), .RX_THR(2), .DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .tx_req(tx_req), .rx_req(rx_req),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .ser_clk(ser_clk),
        .ser_frm(ser_frm), .ser_out(ser_out), .ser_in(ser_in)
    );

    always #10 clk = ~clk;

    function automatic int len_of(input logic [3:0] code);
        return (code < 4'd3) ? 4 : int'(code) + 1;
    endfunction

    function automatic logic [15:0] mask_of(input int len);
        return (len >= 16) ? 16'hFFFF : 16'((32'd1 << len) - 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor and slave, all sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (ser_frm && !prev_frm) begin
            fcyc = 1; nbits = 0; cap = '0; sidx = 0;
            ser_in = slave_word[exp_len-1];
        end else if (ser_frm) begin
            fcyc++;
        end
        if (ser_clk && !prev_clk) begin
            nbits++;
            cap = {cap[14:0], ser_out};
        end
        if (!ser_clk && prev_clk && ser_frm) begin
            sidx++;
            if (sidx < exp_len) ser_in = slave_word[exp_len-1-sidx];
        end
        if (!ser_frm && prev_frm) begin
            last_fcyc = fcyc; last_nbits = nbits; last_cap = cap; fcount++;
        end
        prev_frm = ser_frm;
        prev_clk = ser_clk;
    end

    task automatic cfg_write(input logic [15:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic push_one(input logic [15:0] v);
        @(negedge clk); tx_push = 1'b1; tx_data = v;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop_one(output logic [15:0] v);
        @(negedge clk); v = rx_data; rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 8) begin
            @(negedge clk);
            if (ser_frm) quiet = 0; else quiet++;
        end
    endtask

    // One frame with full checking; loop selects loopback.
    task automatic one_frame(input logic [3:0] code, input logic lp,
                             input logic [15:0] w, input logic [15:0] sw);
        logic [15:0] got;
        logic [15:0] m;
        string tag;
        exp_len = len_of(code);
        m = mask_of(exp_len);
        slave_word = sw;
        tag = (code < 4'd3) ? "R3" : "R2";
        cfg_write({9'd0, 1'b0, 1'b0, lp, code});
        push_one(w);
        wait_idle();
        check({tag, " bit count"}, last_nbits, exp_len);
        check({tag, " ser_out data"}, {16'd0, last_cap}, {16'd0, w & m});
        check("R10 frame cycles", last_fcyc, 2 * DIV * exp_len);
        check("R10 idle clk", {31'd0, ser_clk}, 0);
        pop_one(got);
        if (lp)
            check("R6 loopback rx", {16'd0, got}, {16'd0, w & m});
        else
            check("R5 pin rx", {16'd0, got}, {16'd0, sw & m});
        check("R4 rx upper zero", {16'd0, got & ~m}, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        fork
            begin
                while (cyc < 150000) @(negedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        join_none

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        check("R1 cfg reset", {16'd0, cfg_rdata}, 0);
        check("R10 frm reset", {31'd0, ser_frm}, 0);
        check("R10 clk reset", {31'd0, ser_clk}, 0);
        check("R7 tx_req reset", {31'd0, tx_req}, 1);
        check("R7 rx_req reset", {31'd0, rx_req}, 0);
        check("R8 tx_irq masked", {31'd0, tx_irq}, 0);
        check("R9 rx empty reset", {31'd0, rx_empty}, 1);

        // Readback of reserved upper bits
        cfg_write(16'hFFFF);
        check("R1 upper bits zero", {16'd0, cfg_rdata}, 32'h007F);

        // Directed size codes, loopback with conflicting pin data
        for (int c = 0; c < 16; c++)
            one_frame(4'(c), 1'b1, 16'($urandom), 16'($urandom));

        // Random loopback frames
        for (int i = 0; i < 20; i++)
            one_frame(4'($urandom), 1'b1, 16'($urandom), 16'($urandom));

        // External pin frames
        for (int i = 0; i < 16; i++)
            one_frame(4'($urandom), 1'b0, 16'($urandom), 16'($urandom));
        one_frame(4'hF, 1'b0, 16'h1234, 16'hA5C3);
        one_frame(4'h3, 1'b0, 16'hFFF0, 16'h000F);

        // Thresholds and interrupt gating: code 3, loopback, both enables
        begin
            logic [15:0] got;
            exp_len = 4;
            slave_word = '0;
            cfg_write(16'h0073);
            check("R8 tx_irq enabled", {31'd0, tx_irq}, 1);
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                tx_push = 1'b1; tx_data = 16'(i + 5);
                @(negedge clk);
            end
            tx_push = 1'b0;
            check("R7 tx_req above thr", {31'd0, tx_req}, 0);
            check("R8 tx_irq follows", {31'd0, tx_irq}, 0);
            wait_idle();
            check("R7 rx_req at 4", {31'd0, rx_req}, 1);
            check("R8 rx_irq on", {31'd0, rx_irq}, 1);
            check("R7 tx_req empty", {31'd0, tx_req}, 1);
            cfg_write(16'h0053);
            check("R8 rx_irq masked", {31'd0, rx_irq}, 0);
            check("R8 rx_req kept", {31'd0, rx_req}, 1);
            for (int i = 0; i < 3; i++) begin
                pop_one(got);
                check("R6 order", {16'd0, got}, 32'(i + 5));
            end
            check("R7 rx_req below", {31'd0, rx_req}, 0);
            cfg_write(16'h0073);
            check("R8 rx_irq no flag", {31'd0, rx_irq}, 0);
            pop_one(got);
            check("R6 order", {16'd0, got}, 32'd8);
            check("R9 drained", {31'd0, rx_empty}, 1);
        end

        // Overfill both queues: code 7
        begin
            logic [15:0] got;
            int f0;
            exp_len = 8;
            cfg_write(16'h0017);
            f0 = fcount;
            @(negedge clk);
            for (int i = 0; i < 6; i++) begin
                tx_push = 1'b1; tx_data = 16'h0A0 + 16'(i);
                @(negedge clk);
            end
            tx_push = 1'b0;
            check("R9 tx_full", {31'd0, tx_full}, 1);
            wait_idle();
            check("R9 frames sent", fcount - f0, 5);
            for (int i = 0; i < 4; i++) begin
                pop_one(got);
                check("R9 kept words", {16'd0, got}, 32'h0A0 + 32'(i));
            end
            check("R9 fifth dropped", {31'd0, rx_empty}, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule